// File: doc/BRIEF.md
# Surface Copy Path Selector

This block decides which of four copy mechanisms should carry out a rectangle-to-rectangle surface copy. It receives a full descriptor for the source surface and one for the destination surface (base offset, row pitch, bytes per pixel, width, height, depth, memory placement and the corner coordinates of the copied rectangle) plus a flag that says whether the rendering engine is of the newer generation. From these it works out the eligibility of each mechanism and picks the first eligible one in a fixed priority order.

The selection is purely combinational: `path_sel` and `scaled` follow the inputs in the same cycle. A pitch of zero means the surface is stored in swizzled (bit-interleaved) order rather than row by row. When a request is presented with `req_valid` and no mechanism qualifies, the select is all zero and a sticky error flag is raised on the next clock. Only reset clears that flag. Carrying out the copy is left to the mechanism that is selected.

Top module: `copy_path_sel`

## Requirements
- R1: `scaled` is 1 exactly when the horizontal extent (x1 - x0) or the vertical extent (y1 - y0) of the source differs from that of the destination, with extents taken modulo 2^16.
- R2: `path_sel` is one-hot or all zero. Bit 0 is the linear copy engine, bit 1 the scaled image engine, bit 2 the 3D blit and bit 3 the software fallback. The lowest-numbered eligible path wins.
- R3: The linear copy engine is eligible only when both pitches are nonzero and the transfer is not scaled.
- R4: The scaled image engine requires a nonzero source pitch, source width and height each at least 2, the bitwise OR of source width and height at most 1024, source and destination depth at most 1, and a destination offset that is a multiple of 64.
- R5: For the scaled image engine, a destination with zero pitch needs width and height each at least 2, with the OR of width and height at most 2048. A destination with nonzero pitch must be in video memory and have a pitch that is a multiple of 64.
- R6: The 3D blit requires `newer_gen`=1, a destination offset and pitch that are both multiples of 64, a destination depth at most 1, and a destination width and height each at least 2.
- R7: The 3D blit is ineligible when either side has more than 4 bytes per pixel, or when the destination has 1 byte per pixel and zero pitch.
- R8: The software fallback is eligible for every unscaled transfer, so an unscaled transfer never leaves `path_sel` all zero.
- R9: `no_path_err` is 0 after reset. It becomes 1 on the clock edge after a cycle in which `req_valid`=1 and `path_sel` is zero, and then stays 1 until reset. A cycle with `req_valid`=0 never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Descriptors carry a request this cycle |
| newer_gen | input | 1 | Rendering engine is the newer generation |
| src_offset | input | 32 | Source base byte offset |
| src_pitch | input | 16 | Source row pitch in bytes, 0 = swizzled |
| src_cpp | input | 4 | Source bytes per pixel |
| src_w | input | 16 | Source surface width |
| src_h | input | 16 | Source surface height |
| src_d | input | 16 | Source surface depth |
| src_vram | input | 1 | Source resides in video memory |
| src_x0 | input | 16 | Source rectangle left |
| src_x1 | input | 16 | Source rectangle right (exclusive) |
| src_y0 | input | 16 | Source rectangle top |
| src_y1 | input | 16 | Source rectangle bottom (exclusive) |
| dst_offset | input | 32 | Destination base byte offset |
| dst_pitch | input | 16 | Destination row pitch in bytes, 0 = swizzled |
| dst_cpp | input | 4 | Destination bytes per pixel |
| dst_w | input | 16 | Destination surface width |
| dst_h | input | 16 | Destination surface height |
| dst_d | input | 16 | Destination surface depth |
| dst_vram | input | 1 | Destination resides in video memory |
| dst_x0 | input | 16 | Destination rectangle left |
| dst_x1 | input | 16 | Destination rectangle right (exclusive) |
| dst_y0 | input | 16 | Destination rectangle top |
| dst_y1 | input | 16 | Destination rectangle bottom (exclusive) |
| path_sel | output | 4 | One-hot chosen path, all zero when none |
| scaled | output | 1 | Source and destination extents differ |
| no_path_err | output | 1 | Sticky: a valid request found no path |

## Verification
The bench targets the size limits at their exact edges: 1024 and 1025 on the source, 2048 and 2049 on a swizzled destination, and the OR quirk in which a 1024x2 source is rejected. A design that used a maximum instead of the OR would wrongly send that source to the scaled engine. Priority is tested with descriptors eligible for several paths at once, where a reversed or non-exclusive picker shows up as a wrong or multi-bit select. The blit byte-per-pixel exclusions and an unaligned offset are tested to catch a blit that is chosen too freely. The error flag is checked for staying clear on an invalid cycle, for setting on a valid cycle with no path, and for holding through a later good request. A flag that is not sticky, or that latches without `req_valid`, fails one of these checks.

// File: rtl/copy_sel_pkg.sv
package copy_sel_pkg;
  parameter int OFS_W      = 32;
  parameter int PITCH_W    = 16;
  parameter int CPP_W      = 4;
  parameter int DIM_W      = 16;
  parameter int ALIGN_LOG2 = 6;
  parameter int NPATH      = 4;

  localparam int P_LINEAR = 0;
  localparam int P_SCALER = 1;
  localparam int P_BLIT   = 2;
  localparam int P_SOFT   = 3;

  typedef struct packed {
    logic [OFS_W-1:0]   offset;
    logic [PITCH_W-1:0] pitch;
    logic [CPP_W-1:0]   cpp;
    logic [DIM_W-1:0]   w;
    logic [DIM_W-1:0]   h;
    logic [DIM_W-1:0]   d;
    logic               vram;
    logic [DIM_W-1:0]   x0;
    logic [DIM_W-1:0]   x1;
    logic [DIM_W-1:0]   y0;
    logic [DIM_W-1:0]   y1;
  } surf_desc_t;
endpackage

// File: rtl/copy_sel_extent.sv
module copy_sel_extent
  import copy_sel_pkg::*;
(
  input  surf_desc_t src,
  input  surf_desc_t dst,
  output logic       scaled
);
  logic [DIM_W-1:0] src_ext_x, src_ext_y, dst_ext_x, dst_ext_y;

  always_comb begin
    src_ext_x = src.x1 - src.x0;
    src_ext_y = src.y1 - src.y0;
    dst_ext_x = dst.x1 - dst.x0;
    dst_ext_y = dst.y1 - dst.y0;
    scaled    = (src_ext_x != dst_ext_x) || (src_ext_y != dst_ext_y);
  end
endmodule

// File: rtl/copy_sel_elig.sv
module copy_sel_elig
  import copy_sel_pkg::*;
#(
  parameter int SRC_LIMIT = 1024,
  parameter int SWZ_LIMIT = 2048,
  parameter int MIN_DIM   = 2,
  parameter int MAX_CPP   = 4
) (
  input  surf_desc_t       src,
  input  surf_desc_t       dst,
  input  logic             scaled,
  input  logic             newer_gen,
  output logic [NPATH-1:0] elig
);
  localparam logic [DIM_W-1:0] SRC_LIM = DIM_W'(SRC_LIMIT);
  localparam logic [DIM_W-1:0] SWZ_LIM = DIM_W'(SWZ_LIMIT);
  localparam logic [DIM_W-1:0] DIM_MIN = DIM_W'(MIN_DIM);
  localparam logic [DIM_W-1:0] ONE     = DIM_W'(1);
  localparam logic [CPP_W-1:0] CPP_MAX = CPP_W'(MAX_CPP);
  localparam logic [CPP_W-1:0] CPP_ONE = CPP_W'(1);

  logic src_pitched, dst_pitched;
  logic dst_ofs_al, dst_pitch_al;
  logic src_fits, dst_swz_fits, dst_pitched_ok, flat_both;
  logic blit_size_ok, blit_cpp_ok;

  always_comb begin
    src_pitched    = |src.pitch;
    dst_pitched    = |dst.pitch;
    dst_ofs_al     = ~|dst.offset[ALIGN_LOG2-1:0];
    dst_pitch_al   = ~|dst.pitch[ALIGN_LOG2-1:0];
    flat_both      = (src.d <= ONE) && (dst.d <= ONE);
    src_fits       = ((src.w | src.h) <= SRC_LIM) &&
                     (src.w >= DIM_MIN) && (src.h >= DIM_MIN);
    dst_swz_fits   = ((dst.w | dst.h) <= SWZ_LIM) &&
                     (dst.w >= DIM_MIN) && (dst.h >= DIM_MIN);
    dst_pitched_ok = dst.vram && dst_pitch_al;
    blit_size_ok   = (dst.w >= DIM_MIN) && (dst.h >= DIM_MIN) && (dst.d <= ONE);
    blit_cpp_ok    = (dst.cpp <= CPP_MAX) && (src.cpp <= CPP_MAX) &&
                     !((dst.cpp == CPP_ONE) && !dst_pitched);

    elig           = '0;
    elig[P_LINEAR] = src_pitched && dst_pitched && !scaled;
    elig[P_SCALER] = src_pitched && src_fits && flat_both && dst_ofs_al &&
                     (dst_pitched ? dst_pitched_ok : dst_swz_fits);
    elig[P_BLIT]   = newer_gen && dst_ofs_al && dst_pitch_al &&
                     blit_size_ok && blit_cpp_ok;
    elig[P_SOFT]   = !scaled;
  end
endmodule

// File: rtl/copy_sel_prio.sv
module copy_sel_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_stage
    assign grant[i]   = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
endmodule

// File: rtl/copy_path_sel.sv
module copy_path_sel
  import copy_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               newer_gen,
  input  logic [OFS_W-1:0]   src_offset,
  input  logic [PITCH_W-1:0] src_pitch,
  input  logic [CPP_W-1:0]   src_cpp,
  input  logic [DIM_W-1:0]   src_w,
  input  logic [DIM_W-1:0]   src_h,
  input  logic [DIM_W-1:0]   src_d,
  input  logic               src_vram,
  input  logic [DIM_W-1:0]   src_x0,
  input  logic [DIM_W-1:0]   src_x1,
  input  logic [DIM_W-1:0]   src_y0,
  input  logic [DIM_W-1:0]   src_y1,
  input  logic [OFS_W-1:0]   dst_offset,
  input  logic [PITCH_W-1:0] dst_pitch,
  input  logic [CPP_W-1:0]   dst_cpp,
  input  logic [DIM_W-1:0]   dst_w,
  input  logic [DIM_W-1:0]   dst_h,
  input  logic [DIM_W-1:0]   dst_d,
  input  logic               dst_vram,
  input  logic [DIM_W-1:0]   dst_x0,
  input  logic [DIM_W-1:0]   dst_x1,
  input  logic [DIM_W-1:0]   dst_y0,
  input  logic [DIM_W-1:0]   dst_y1,
  output logic [NPATH-1:0]   path_sel,
  output logic               scaled,
  output logic               no_path_err
);
  surf_desc_t       src_desc, dst_desc;
  logic [NPATH-1:0] elig;
  logic             err_d, err_q;

  always_comb begin
    src_desc = '{offset: src_offset, pitch: src_pitch, cpp: src_cpp,
                 w: src_w, h: src_h, d: src_d, vram: src_vram,
                 x0: src_x0, x1: src_x1, y0: src_y0, y1: src_y1};
    dst_desc = '{offset: dst_offset, pitch: dst_pitch, cpp: dst_cpp,
                 w: dst_w, h: dst_h, d: dst_d, vram: dst_vram,
                 x0: dst_x0, x1: dst_x1, y0: dst_y0, y1: dst_y1};
  end

  copy_sel_extent u_extent (
    .src    (src_desc),
    .dst    (dst_desc),
    .scaled (scaled)
  );

  copy_sel_elig u_elig (
    .src       (src_desc),
    .dst       (dst_desc),
    .scaled    (scaled),
    .newer_gen (newer_gen),
    .elig      (elig)
  );

  copy_sel_prio #(.N(NPATH)) u_prio (
    .req   (elig),
    .grant (path_sel)
  );

  // sticky error: next state then register
  always_comb begin
    err_d = err_q;
    if (req_valid && !(|path_sel)) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign no_path_err = err_q;
endmodule

// File: rtl/copy_path_sel_chk.sv
module copy_path_sel_chk
  import copy_sel_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               newer_gen,
  input logic [PITCH_W-1:0] src_pitch,
  input logic [PITCH_W-1:0] dst_pitch,
  input logic [DIM_W-1:0]   src_w,
  input logic [DIM_W-1:0]   src_h,
  input logic [NPATH-1:0]   path_sel,
  input logic               scaled,
  input logic               no_path_err
);
  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(path_sel));

  assert_linear_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
    path_sel[P_LINEAR] |-> (!scaled && src_pitch != '0 && dst_pitch != '0));

  assert_scaler_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    path_sel[P_SCALER] |-> (src_pitch != '0 && src_w >= 2 && src_h >= 2));

  assert_blit_gen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    path_sel[P_BLIT] |-> newer_gen);

  assert_unscaled_served_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !scaled |-> (path_sel != '0));

  assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && path_sel == '0) |=> no_path_err);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    no_path_err |=> no_path_err);
endmodule

bind copy_path_sel copy_path_sel_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .newer_gen   (newer_gen),
  .src_pitch   (src_pitch),
  .dst_pitch   (dst_pitch),
  .src_w       (src_w),
  .src_h       (src_h),
  .path_sel    (path_sel),
  .scaled      (scaled),
  .no_path_err (no_path_err)
);

// File: tb/copy_path_sel_tb_top.sv
module copy_path_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid, newer_gen;
  logic [31:0] s_ofs, d_ofs;
  logic [15:0] s_pitch, d_pitch;
  logic [3:0]  s_cpp, d_cpp;
  logic [15:0] s_w, s_h, s_d, d_w, d_h, d_d;
  logic        s_vram, d_vram;
  logic [15:0] s_x0, s_x1, s_y0, s_y1, d_x0, d_x1, d_y0, d_y1;
  logic [3:0]  path_sel;
  logic        scaled, no_path_err;

  int checks = 0;
  int fails  = 0;
  logic exp_err = 1'b0;

  copy_path_sel dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .newer_gen(newer_gen),
    .src_offset(s_ofs), .src_pitch(s_pitch), .src_cpp(s_cpp), .src_w(s_w),
    .src_h(s_h), .src_d(s_d), .src_vram(s_vram), .src_x0(s_x0), .src_x1(s_x1),
    .src_y0(s_y0), .src_y1(s_y1),
    .dst_offset(d_ofs), .dst_pitch(d_pitch), .dst_cpp(d_cpp), .dst_w(d_w),
    .dst_h(d_h), .dst_d(d_d), .dst_vram(d_vram), .dst_x0(d_x0), .dst_x1(d_x1),
    .dst_y0(d_y0), .dst_y1(d_y1),
    .path_sel(path_sel), .scaled(scaled), .no_path_err(no_path_err)
  );

  // ---------------- reference model from the requirements ----------------
  function automatic logic ref_scaled();
    logic [15:0] a, b, c, e;
    a = s_x1 - s_x0; b = d_x1 - d_x0;
    c = s_y1 - s_y0; e = d_y1 - d_y0;
    return (a != b) || (c != e);  // R1
  endfunction

  function automatic logic [3:0] ref_sel();
    logic sc, lin, img, blt, sw;
    logic [15:0] sor, dor;
    sc  = ref_scaled();
    sor = s_w | s_h;
    dor = d_w | d_h;
    lin = (s_pitch != 0) && (d_pitch != 0) && !sc;                       // R3
    img = (s_pitch != 0) && (sor <= 1024) && (s_w >= 2) && (s_h >= 2) &&
          (s_d <= 1) && (d_d <= 1) && (d_ofs % 64 == 0);                  // R4
    if (d_pitch == 0) img = img && (dor <= 2048) && (d_w >= 2) && (d_h >= 2); // R5
    else              img = img && d_vram && (d_pitch % 64 == 0);
    blt = newer_gen && (d_ofs % 64 == 0) && (d_pitch % 64 == 0) &&
          (d_d <= 1) && (d_w >= 2) && (d_h >= 2);                         // R6
    blt = blt && (s_cpp <= 4) && (d_cpp <= 4) && !(d_cpp == 1 && d_pitch == 0); // R7
    sw  = !sc;                                                            // R8
    if (lin) return 4'b0001;                                              // R2
    if (img) return 4'b0010;
    if (blt) return 4'b0100;
    if (sw)  return 4'b1000;
    return 4'b0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // set a descriptor pair eligible for the linear engine
  task automatic base();
    req_valid = 1'b1; newer_gen = 1'b0;
    s_ofs = 0; s_pitch = 256; s_cpp = 4; s_w = 64; s_h = 64; s_d = 1; s_vram = 1;
    s_x0 = 2; s_x1 = 10; s_y0 = 3; s_y1 = 9;
    d_ofs = 0; d_pitch = 256; d_cpp = 4; d_w = 64; d_h = 64; d_d = 1; d_vram = 1;
    d_x0 = 0; d_x1 = 8; d_y0 = 0; d_y1 = 6;
  endtask

  task automatic apply(input string req);
    logic [3:0] es;
    @(negedge clk);
    #1;
    es = ref_sel();
    check(req, {28'd0, path_sel}, {28'd0, es});
    check("R1", {31'd0, scaled}, {31'd0, ref_scaled()});
    if (req_valid && es == 4'b0000) exp_err = 1'b1;
    @(posedge clk);
    #1;
    check("R9", {31'd0, no_path_err}, {31'd0, exp_err});
  endtask

  function automatic logic [15:0] pick_dim();
    case ($urandom_range(0, 7))
      0: return 16'd1;
      1: return 16'd2;
      2: return 16'd1024;
      3: return 16'd1025;
      4: return 16'd2048;
      5: return 16'd2049;
      default: return 16'($urandom_range(2, 300));
    endcase
  endfunction

  function automatic logic [15:0] pick_pitch();
    case ($urandom_range(0, 3))
      0: return 16'd0;
      1: return 16'd40;
      default: return 16'(64 * $urandom_range(1, 16));
    endcase
  endfunction

  function automatic logic [3:0] pick_cpp();
    case ($urandom_range(0, 3))
      0: return 4'd1;
      1: return 4'd2;
      2: return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    exp_err = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    base();
    do_reset();
    @(negedge clk);
    check("R9 reset", {31'd0, no_path_err}, 32'd0);

    base(); apply("R3 linear chosen");
    base(); newer_gen = 1; apply("R2 linear beats blit");
    base(); s_pitch = 0; s_cpp = 4; newer_gen = 1; apply("R6 blit");
    base(); s_pitch = 0; newer_gen = 0; apply("R8 software");
    base(); d_ofs = 32; s_pitch = 0; newer_gen = 1; apply("R6 unaligned offset");
    base(); s_pitch = 0; d_pitch = 0; d_cpp = 1; newer_gen = 1; apply("R7 byte swizzled dst");
    base(); s_pitch = 0; s_cpp = 8; newer_gen = 1; apply("R7 wide src");
    // scaled transfers
    base(); s_x1 = 20; s_w = 512; s_h = 512; apply("R4 scaler pitched dst");
    base(); s_x1 = 20; s_w = 1024; s_h = 2; newer_gen = 1; apply("R4 or-limit quirk");
    base(); s_x1 = 20; s_w = 1024; s_h = 1024; apply("R4 max src");
    base(); s_x1 = 20; d_pitch = 0; d_w = 2048; d_h = 2048; apply("R5 swizzled max");
    base(); s_x1 = 20; d_pitch = 0; d_w = 2049; d_h = 4; newer_gen = 1; apply("R5 swizzled too big");
    base(); s_x1 = 20; d_d = 2; newer_gen = 1; d_pitch = 128; apply("R4 deep dst");

    for (int i = 0; i < 400; i++) begin
      req_valid = 1'b1;
      newer_gen = 1'($urandom_range(0, 1));
      s_ofs = 64 * $urandom_range(0, 100) + (($urandom_range(0, 3) == 0) ? 16 : 0);
      d_ofs = 64 * $urandom_range(0, 100) + (($urandom_range(0, 3) == 0) ? 8 : 0);
      s_pitch = pick_pitch(); d_pitch = pick_pitch();
      s_cpp = pick_cpp(); d_cpp = pick_cpp();
      s_w = pick_dim(); s_h = pick_dim(); d_w = pick_dim(); d_h = pick_dim();
      s_d = 16'($urandom_range(0, 2)); d_d = 16'($urandom_range(0, 2));
      s_vram = 1'($urandom_range(0, 1)); d_vram = 1'($urandom_range(0, 1));
      s_x0 = 16'($urandom_range(0, 7)); s_x1 = s_x0 + 16'($urandom_range(0, 9));
      s_y0 = 16'($urandom_range(0, 7)); s_y1 = s_y0 + 16'($urandom_range(0, 9));
      d_x0 = 16'($urandom_range(0, 7)); d_y0 = 16'($urandom_range(0, 7));
      if ($urandom_range(0, 9) < 6) begin
        d_x1 = d_x0 + (s_x1 - s_x0); d_y1 = d_y0 + (s_y1 - s_y0);
      end else begin
        d_x1 = d_x0 + 16'($urandom_range(0, 9)); d_y1 = d_y0 + 16'($urandom_range(0, 9));
      end
      apply("R2 random");
    end

    // error flag behaviour from a clean reset
    base();
    do_reset();
    @(negedge clk);
    check("R9 cleared by reset", {31'd0, no_path_err}, 32'd0);
    base(); s_x1 = 20; d_vram = 0; req_valid = 0; apply("R9 invalid no path");
    base(); s_x1 = 20; d_vram = 0; req_valid = 1; apply("R9 valid no path");
    base(); apply("R9 sticky");
    base(); apply("R9 still sticky");

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule